// File: doc/BRIEF.md
# Thermal and Supply Threshold Monitor

This block watches digitized readings from several on-die temperature sites and several supply rails, and raises alarms when a reading crosses a programmable limit. Temperature readings arrive one at a time with a valid strobe and a site index. Rail readings arrive the same way with a rail index. Each site is checked against two limits. The warning limit leads to a throttle interrupt. The critical limit leads to a forced-shutdown request that stays asserted until reset. Each rail is checked against its own minimum and maximum, which gives under-voltage and over-voltage status.

Each condition must hold for a programmable number of consecutive samples of its own channel before it fires. This filters out single noisy codes. Once a condition has fired, it stays disarmed until a reading on that channel passes back beyond the limit by a programmable hysteresis band. The status bits are sticky, and software clears them one at a time with per-bit clear pulses. The interrupt lines are the OR of the sticky status bits in their group.

Top module: `thermal_supply_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, every status bit, both interrupt lines and `shutdown_req` go to 0, and all sample runs and armed states are reset.
- R2: A site sets its bit in `warn_sts` once `persist` consecutive samples of that site have a code greater than or equal to `warn_lim`. `throttle_irq` is high whenever any `warn_sts` bit is set.
- R3: A site sets its bit in `crit_sts` once `persist` consecutive samples of that site have a code strictly above `crit_lim`. A code equal to `crit_lim` does not count. `shutdown_req` rises in the same cycle.
- R4: Once `shutdown_req` is high, it stays high until reset. Clearing `crit_sts` and normal readings do not lower it.
- R5: A sample of a channel that does not meet the condition restarts that channel's run. `persist` = 0 behaves as 1. The status is updated on the clock edge that takes the final qualifying sample.
- R6: After a condition fires, it cannot fire again until a sample of that channel passes the release point. For warning the release point is code + `temp_hyst` < `warn_lim`. For critical it is code + `temp_hyst` <= `crit_lim`. For under-voltage it is code >= min + `rail_hyst`. For over-voltage it is code + `rail_hyst` <= max.
- R7: Status bits stay set until the matching bit of `clr_warn`, `clr_crit`, `clr_uv` or `clr_ov` is pulsed. Clearing one bit leaves the other bits unchanged. A set event in the same cycle wins over a clear.
- R8: Runs are kept per channel. Samples of other channels neither advance nor break a channel's run.
- R9: Rail k sets `uv_sts[k]` after `persist` consecutive samples with a code strictly below `rail_min[k*DW +: DW]`. A code equal to the minimum does not count.
- R10: Rail k sets `ov_sts[k]` after `persist` consecutive samples with a code strictly above `rail_max[k*DW +: DW]`. A code equal to the maximum does not count. `rail_irq` is high whenever any `uv_sts` or `ov_sts` bit is set.
- R11: A sample whose index is not below the number of sites (or of rails) has no effect on any status or run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_valid | input | 1 | Temperature sample strobe |
| temp_chan | input | TIW | Site index of the temperature sample |
| temp_code | input | DW | Temperature code |
| rail_valid | input | 1 | Rail sample strobe |
| rail_chan | input | RIW | Rail index of the rail sample |
| rail_code | input | DW | Rail voltage code |
| warn_lim | input | DW | Throttle warning limit (at or above trips) |
| crit_lim | input | DW | Critical limit (strictly above trips) |
| temp_hyst | input | DW | Temperature hysteresis band |
| rail_min | input | N_RAIL*DW | Per-rail minimum limits, rail k in bits [k*DW +: DW] |
| rail_max | input | N_RAIL*DW | Per-rail maximum limits, rail k in bits [k*DW +: DW] |
| rail_hyst | input | DW | Rail hysteresis band |
| persist | input | CW | Consecutive samples needed to fire (0 acts as 1) |
| clr_warn | input | N_TEMP | Per-site clear pulses for warning status |
| clr_crit | input | N_TEMP | Per-site clear pulses for critical status |
| clr_uv | input | N_RAIL | Per-rail clear pulses for under-voltage status |
| clr_ov | input | N_RAIL | Per-rail clear pulses for over-voltage status |
| warn_sts | output | N_TEMP | Sticky warning status per site |
| crit_sts | output | N_TEMP | Sticky critical status per site |
| uv_sts | output | N_RAIL | Sticky under-voltage status per rail |
| ov_sts | output | N_RAIL | Sticky over-voltage status per rail |
| throttle_irq | output | 1 | Throttle interrupt |
| rail_irq | output | 1 | Supply fault interrupt |
| shutdown_req | output | 1 | Forced-shutdown request, held until reset |

## Verification
The assertions check several rules on every cycle. The shutdown request never falls once it is high. A warning or critical bit only rises after a sample of that same site that met the matching limit. An uncleared status bit never drops. An out-of-range sample index leaves every status bit unchanged. Only the bench scenarios can show how many samples each condition needs, including the equality boundaries, the restart of an interrupted run, and `persist` = 0. The same holds for the hysteresis re-arm sequence, per-channel independence, and that shutdown survives a clear of the critical status until reset.

// File: rtl/tsm_pkg.sv
// Shared types for the thermal and supply threshold monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package tsm_pkg;

    // Comparison sense of one threshold check.
    typedef enum logic [1:0] {
        CMP_AT_OR_ABOVE = 2'd0,
        CMP_ABOVE       = 2'd1,
        CMP_BELOW       = 2'd2
    } cmp_kind_e;

endpackage

// File: rtl/tsm_cmp.sv
// Threshold comparator with hysteresis release point.
// hit      : the reading meets the alarm condition against the limit.
// clear_ok : the reading has passed back beyond the limit by the band.
// Assumes: unsigned codes; arithmetic is widened by one bit so no sum wraps.
module tsm_cmp #(
    parameter int                  DW   = 10,
    parameter tsm_pkg::cmp_kind_e  KIND = tsm_pkg::CMP_ABOVE
) (
    input  logic [DW-1:0] code,
    input  logic [DW-1:0] limit,
    input  logic [DW-1:0] band,
    output logic          hit,
    output logic          clear_ok
);
    localparam int XW = DW + 1;

    logic [XW-1:0] code_x;
    logic [XW-1:0] lim_x;
    logic [XW-1:0] code_plus_band;
    logic [XW-1:0] lim_plus_band;

    assign code_x         = {1'b0, code};
    assign lim_x          = {1'b0, limit};
    assign code_plus_band = code_x + {1'b0, band};
    assign lim_plus_band  = lim_x + {1'b0, band};

    generate
        if (KIND == tsm_pkg::CMP_AT_OR_ABOVE) begin : g_ge
            // Warning style: trip at or above, release below limit minus band.
            always_comb begin
                hit      = code_x >= lim_x;
                clear_ok = code_plus_band < lim_x;
            end
        end else if (KIND == tsm_pkg::CMP_ABOVE) begin : g_gt
            // Critical / over-voltage style: trip strictly above.
            always_comb begin
                hit      = code_x > lim_x;
                clear_ok = code_plus_band <= lim_x;
            end
        end else begin : g_lt
            // Under-voltage style: trip strictly below.
            always_comb begin
                hit      = code_x < lim_x;
                clear_ok = code_x >= lim_plus_band;
            end
        end
    endgenerate

endmodule

// File: rtl/tsm_cond.sv
// One monitored condition of one channel: persistence filter, armed state
// with hysteresis release, and a sticky status bit with a clear pulse.
// Assumes: smp is high for exactly the cycles carrying a sample of this
// channel; hit/clear_ok describe that sample.
module tsm_cond #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp,
    input  logic          hit,
    input  logic          clear_ok,
    input  logic [CW-1:0] persist,
    input  logic          clr,
    output logic          sts,
    output logic          set_evt
);
    localparam int RW = CW + 1;

    logic [CW-1:0] run_q, run_d;
    logic          live_q, live_d;
    logic          sts_q;
    logic [RW-1:0] need;
    logic [RW-1:0] run_inc;

    assign need    = (persist == '0) ? RW'(1) : {1'b0, persist};
    assign run_inc = {1'b0, run_q} + RW'(1);

    // Next-state of the run counter and the fired (disarmed) flag.
    always_comb begin
        run_d   = run_q;
        live_d  = live_q;
        set_evt = 1'b0;
        if (smp) begin
            if (hit) begin
                if (!live_q) begin
                    if (run_inc >= need) begin
                        live_d  = 1'b1;
                        run_d   = '0;
                        set_evt = 1'b1;
                    end else begin
                        run_d = run_q + 1'b1;
                    end
                end
            end else begin
                run_d = '0;
                if (live_q && clear_ok) begin
                    live_d = 1'b0;
                end
            end
        end
    end

    // State registers; a set event wins over a clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            live_q <= 1'b0;
            sts_q  <= 1'b0;
        end else begin
            run_q  <= run_d;
            live_q <= live_d;
            sts_q  <= set_evt | (sts_q & ~clr);
        end
    end

    assign sts = sts_q;

endmodule

// File: rtl/thermal_supply_monitor.sv
// Thermal and supply threshold monitor.
// Temperature sites get a warning check (at or above) and a critical check
// (strictly above); rails get under- and over-voltage window checks. Any
// critical event latches the shutdown request until reset.
// Assumes: at most one temperature and one rail sample per cycle; limits are
// quasi-static; out-of-range channel indices are dropped.
module thermal_supply_monitor #(
    parameter int N_TEMP = 3,
    parameter int N_RAIL = 3,
    parameter int DW     = 10,
    parameter int CW     = 4,
    localparam int TIW   = (N_TEMP > 1) ? $clog2(N_TEMP) : 1,
    localparam int RIW   = (N_RAIL > 1) ? $clog2(N_RAIL) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 temp_valid,
    input  logic [TIW-1:0]       temp_chan,
    input  logic [DW-1:0]        temp_code,
    input  logic                 rail_valid,
    input  logic [RIW-1:0]       rail_chan,
    input  logic [DW-1:0]        rail_code,
    input  logic [DW-1:0]        warn_lim,
    input  logic [DW-1:0]        crit_lim,
    input  logic [DW-1:0]        temp_hyst,
    input  logic [N_RAIL*DW-1:0] rail_min,
    input  logic [N_RAIL*DW-1:0] rail_max,
    input  logic [DW-1:0]        rail_hyst,
    input  logic [CW-1:0]        persist,
    input  logic [N_TEMP-1:0]    clr_warn,
    input  logic [N_TEMP-1:0]    clr_crit,
    input  logic [N_RAIL-1:0]    clr_uv,
    input  logic [N_RAIL-1:0]    clr_ov,
    output logic [N_TEMP-1:0]    warn_sts,
    output logic [N_TEMP-1:0]    crit_sts,
    output logic [N_RAIL-1:0]    uv_sts,
    output logic [N_RAIL-1:0]    ov_sts,
    output logic                 throttle_irq,
    output logic                 rail_irq,
    output logic                 shutdown_req
);
    logic [N_TEMP-1:0] crit_set;
    logic              sd_q;

    // Per-site warning and critical conditions.
    generate
        for (genvar i = 0; i < N_TEMP; i++) begin : g_site
            logic sel;
            logic w_hit, w_rel, c_hit, c_rel;
            logic w_set;

            assign sel = temp_valid && (temp_chan == TIW'(i));

            tsm_cmp #(.DW(DW), .KIND(tsm_pkg::CMP_AT_OR_ABOVE)) u_wcmp (
                .code(temp_code), .limit(warn_lim), .band(temp_hyst),
                .hit(w_hit), .clear_ok(w_rel)
            );
            tsm_cmp #(.DW(DW), .KIND(tsm_pkg::CMP_ABOVE)) u_ccmp (
                .code(temp_code), .limit(crit_lim), .band(temp_hyst),
                .hit(c_hit), .clear_ok(c_rel)
            );
            tsm_cond #(.CW(CW)) u_wcond (
                .clk(clk), .rst_n(rst_n), .smp(sel), .hit(w_hit),
                .clear_ok(w_rel), .persist(persist), .clr(clr_warn[i]),
                .sts(warn_sts[i]), .set_evt(w_set)
            );
            tsm_cond #(.CW(CW)) u_ccond (
                .clk(clk), .rst_n(rst_n), .smp(sel), .hit(c_hit),
                .clear_ok(c_rel), .persist(persist), .clr(clr_crit[i]),
                .sts(crit_sts[i]), .set_evt(crit_set[i])
            );
        end
    endgenerate

    // Per-rail under- and over-voltage conditions.
    generate
        for (genvar k = 0; k < N_RAIL; k++) begin : g_rail
            logic sel;
            logic u_hit, u_rel, o_hit, o_rel;
            logic u_set, o_set;

            assign sel = rail_valid && (rail_chan == RIW'(k));

            tsm_cmp #(.DW(DW), .KIND(tsm_pkg::CMP_BELOW)) u_ucmp (
                .code(rail_code), .limit(rail_min[k*DW +: DW]), .band(rail_hyst),
                .hit(u_hit), .clear_ok(u_rel)
            );
            tsm_cmp #(.DW(DW), .KIND(tsm_pkg::CMP_ABOVE)) u_ocmp (
                .code(rail_code), .limit(rail_max[k*DW +: DW]), .band(rail_hyst),
                .hit(o_hit), .clear_ok(o_rel)
            );
            tsm_cond #(.CW(CW)) u_ucond (
                .clk(clk), .rst_n(rst_n), .smp(sel), .hit(u_hit),
                .clear_ok(u_rel), .persist(persist), .clr(clr_uv[k]),
                .sts(uv_sts[k]), .set_evt(u_set)
            );
            tsm_cond #(.CW(CW)) u_ocond (
                .clk(clk), .rst_n(rst_n), .smp(sel), .hit(o_hit),
                .clear_ok(o_rel), .persist(persist), .clr(clr_ov[k]),
                .sts(ov_sts[k]), .set_evt(o_set)
            );
        end
    endgenerate

    // Shutdown latch: any critical set event, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_q <= 1'b0;
        end else begin
            sd_q <= sd_q | (|crit_set);
        end
    end

    // Interrupt lines follow the sticky status groups.
    always_comb begin
        throttle_irq = |warn_sts;
        rail_irq     = |(uv_sts | ov_sts);
        shutdown_req = sd_q;
    end

endmodule

// File: rtl/tsm_chk.sv
// Assertion checker for thermal_supply_monitor, attached by bind below.
// Assumes: same parameters as the monitored instance.
module tsm_chk #(
    parameter int N_TEMP = 3,
    parameter int N_RAIL = 3,
    parameter int DW     = 10,
    parameter int CW     = 4,
    localparam int TIW   = (N_TEMP > 1) ? $clog2(N_TEMP) : 1,
    localparam int RIW   = (N_RAIL > 1) ? $clog2(N_RAIL) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 temp_valid,
    input logic [TIW-1:0]       temp_chan,
    input logic [DW-1:0]        temp_code,
    input logic                 rail_valid,
    input logic [RIW-1:0]       rail_chan,
    input logic [DW-1:0]        warn_lim,
    input logic [DW-1:0]        crit_lim,
    input logic [N_TEMP-1:0]    clr_warn,
    input logic [N_TEMP-1:0]    clr_crit,
    input logic [N_RAIL-1:0]    clr_uv,
    input logic [N_RAIL-1:0]    clr_ov,
    input logic [N_TEMP-1:0]    warn_sts,
    input logic [N_TEMP-1:0]    crit_sts,
    input logic [N_RAIL-1:0]    uv_sts,
    input logic [N_RAIL-1:0]    ov_sts,
    input logic                 shutdown_req
);
    // R4
    shutdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> shutdown_req);

    // R3
    shutdown_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_req) |-> (|crit_sts));

    generate
        for (genvar i = 0; i < N_TEMP; i++) begin : g_t
            // R2
            warn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $rose(warn_sts[i])) |->
                $past(temp_valid && (int'(temp_chan) == i) && (temp_code >= warn_lim)));
            // R3
            crit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $rose(crit_sts[i])) |->
                $past(temp_valid && (int'(temp_chan) == i) && (temp_code > crit_lim)));
        end
    endgenerate

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        (((($past(warn_sts) & ~$past(clr_warn)) & ~warn_sts) == '0) &&
         ((($past(crit_sts) & ~$past(clr_crit)) & ~crit_sts) == '0) &&
         ((($past(uv_sts)   & ~$past(clr_uv))   & ~uv_sts)   == '0) &&
         ((($past(ov_sts)   & ~$past(clr_ov))   & ~ov_sts)   == '0)));

    // R9
    uv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ((uv_sts & ~$past(uv_sts)) != '0)) |-> $past(rail_valid));

    // R11
    temp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_valid && (int'(temp_chan) >= N_TEMP) && !rail_valid &&
         (clr_warn == '0) && (clr_crit == '0))
        |=> ($stable(warn_sts) && $stable(crit_sts)));

    // R11
    rail_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_valid && (int'(rail_chan) >= N_RAIL) &&
         (clr_uv == '0) && (clr_ov == '0))
        |=> ($stable(uv_sts) && $stable(ov_sts)));

endmodule

bind thermal_supply_monitor tsm_chk #(
    .N_TEMP(N_TEMP), .N_RAIL(N_RAIL), .DW(DW), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_chan(temp_chan),
    .temp_code(temp_code), .rail_valid(rail_valid), .rail_chan(rail_chan),
    .warn_lim(warn_lim), .crit_lim(crit_lim), .clr_warn(clr_warn),
    .clr_crit(clr_crit), .clr_uv(clr_uv), .clr_ov(clr_ov),
    .warn_sts(warn_sts), .crit_sts(crit_sts), .uv_sts(uv_sts),
    .ov_sts(ov_sts), .shutdown_req(shutdown_req)
);

// File: tb/sim_thermal_supply_monitor.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for clears, hysteresis, persist = 0, shutdown hold and reset.
module sim_thermal_supply_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 3;
    localparam int NR = 3;
    localparam int DW = 10;
    localparam int CW = 4;

    typedef struct packed {
        logic          is_rail;
        logic [1:0]    chan;
        logic [DW-1:0] code;
        logic [2:0]    ew;
        logic [2:0]    ec;
        logic [2:0]    eu;
        logic [2:0]    eo;
        logic          esd;
    } vec_t;

    // warn 400, crit 500, temp band 20, rail min 200/210/220, max 300/310/320, persist 2
    localparam int NV = 22;
    localparam vec_t TABLE [NV] = '{
        '{1'b0, 2'd0, 10'd400, 3'b000, 3'b000, 3'b000, 3'b000, 1'b0}, // R5 run starts
        '{1'b0, 2'd0, 10'd399, 3'b000, 3'b000, 3'b000, 3'b000, 1'b0}, // R5 run broken
        '{1'b0, 2'd0, 10'd400, 3'b000, 3'b000, 3'b000, 3'b000, 1'b0}, // R5 restart
        '{1'b0, 2'd1, 10'd450, 3'b000, 3'b000, 3'b000, 3'b000, 1'b0}, // R8 other site
        '{1'b0, 2'd0, 10'd400, 3'b001, 3'b000, 3'b000, 3'b000, 1'b0}, // R2 equal fires
        '{1'b0, 2'd1, 10'd500, 3'b011, 3'b000, 3'b000, 3'b000, 1'b0}, // R3 equal no crit
        '{1'b0, 2'd1, 10'd501, 3'b011, 3'b000, 3'b000, 3'b000, 1'b0}, // R3 run 1
        '{1'b0, 2'd1, 10'd501, 3'b011, 3'b010, 3'b000, 3'b000, 1'b1}, // R3 crit + shutdown
        '{1'b0, 2'd3, 10'd600, 3'b011, 3'b010, 3'b000, 3'b000, 1'b1}, // R11 bad site
        '{1'b0, 2'd3, 10'd600, 3'b011, 3'b010, 3'b000, 3'b000, 1'b1}, // R11 bad site
        '{1'b1, 2'd0, 10'd199, 3'b011, 3'b010, 3'b000, 3'b000, 1'b1}, // R9 run 1
        '{1'b1, 2'd0, 10'd199, 3'b011, 3'b010, 3'b001, 3'b000, 1'b1}, // R9 uv fires
        '{1'b1, 2'd1, 10'd210, 3'b011, 3'b010, 3'b001, 3'b000, 1'b1}, // R9 equal min
        '{1'b1, 2'd1, 10'd210, 3'b011, 3'b010, 3'b001, 3'b000, 1'b1}, // R9 equal min
        '{1'b1, 2'd2, 10'd321, 3'b011, 3'b010, 3'b001, 3'b000, 1'b1}, // R10 run 1
        '{1'b1, 2'd2, 10'd321, 3'b011, 3'b010, 3'b001, 3'b100, 1'b1}, // R10 ov fires
        '{1'b1, 2'd2, 10'd320, 3'b011, 3'b010, 3'b001, 3'b100, 1'b1}, // R10 equal max
        '{1'b1, 2'd3, 10'd0,   3'b011, 3'b010, 3'b001, 3'b100, 1'b1}, // R11 bad rail
        '{1'b1, 2'd3, 10'd0,   3'b011, 3'b010, 3'b001, 3'b100, 1'b1}, // R11 bad rail
        '{1'b0, 2'd2, 10'd400, 3'b011, 3'b010, 3'b001, 3'b100, 1'b1}, // R8 run 1
        '{1'b0, 2'd1, 10'd0,   3'b011, 3'b010, 3'b001, 3'b100, 1'b1}, // R8 other site
        '{1'b0, 2'd2, 10'd400, 3'b111, 3'b010, 3'b001, 3'b100, 1'b1}  // R8 run kept
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             temp_valid = 1'b0;
    logic [1:0]       temp_chan = '0;
    logic [DW-1:0]    temp_code = '0;
    logic             rail_valid = 1'b0;
    logic [1:0]       rail_chan = '0;
    logic [DW-1:0]    rail_code = '0;
    logic [DW-1:0]    warn_lim = 10'd400;
    logic [DW-1:0]    crit_lim = 10'd500;
    logic [DW-1:0]    temp_hyst = 10'd20;
    logic [NR*DW-1:0] rail_min = {10'd220, 10'd210, 10'd200};
    logic [NR*DW-1:0] rail_max = {10'd320, 10'd310, 10'd300};
    logic [DW-1:0]    rail_hyst = 10'd10;
    logic [CW-1:0]    persist = 4'd2;
    logic [NT-1:0]    clr_warn = '0;
    logic [NT-1:0]    clr_crit = '0;
    logic [NR-1:0]    clr_uv = '0;
    logic [NR-1:0]    clr_ov = '0;
    logic [NT-1:0]    warn_sts, crit_sts;
    logic [NR-1:0]    uv_sts, ov_sts;
    logic             throttle_irq, rail_irq, shutdown_req;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    thermal_supply_monitor #(.N_TEMP(NT), .N_RAIL(NR), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .temp_valid(temp_valid), .temp_chan(temp_chan), .temp_code(temp_code),
        .rail_valid(rail_valid), .rail_chan(rail_chan), .rail_code(rail_code),
        .warn_lim(warn_lim), .crit_lim(crit_lim), .temp_hyst(temp_hyst),
        .rail_min(rail_min), .rail_max(rail_max), .rail_hyst(rail_hyst),
        .persist(persist), .clr_warn(clr_warn), .clr_crit(clr_crit),
        .clr_uv(clr_uv), .clr_ov(clr_ov),
        .warn_sts(warn_sts), .crit_sts(crit_sts), .uv_sts(uv_sts),
        .ov_sts(ov_sts), .throttle_irq(throttle_irq), .rail_irq(rail_irq),
        .shutdown_req(shutdown_req)
    );

    // Compare every output against expected status; irq lines derived from it.
    task automatic check_state(input string req, input logic [2:0] ew,
                               input logic [2:0] ec, input logic [2:0] eu,
                               input logic [2:0] eo, input logic esd);
        logic [15:0] act, exp;
        act = {warn_sts, crit_sts, uv_sts, ov_sts, shutdown_req, throttle_irq, rail_irq};
        exp = {ew, ec, eu, eo, esd, |ew, |(eu | eo)};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One sample presented for a single cycle; returns at the next falling edge.
    task automatic sample(input logic is_rail, input logic [1:0] ch, input logic [DW-1:0] code);
        @(negedge clk);
        if (is_rail) begin
            rail_valid = 1'b1; rail_chan = ch; rail_code = code;
        end else begin
            temp_valid = 1'b1; temp_chan = ch; temp_code = code;
        end
        @(negedge clk);
        rail_valid = 1'b0;
        temp_valid = 1'b0;
    endtask

    // One-cycle clear pulse.
    task automatic clear(input logic [2:0] w, input logic [2:0] c,
                         input logic [2:0] u, input logic [2:0] o);
        @(negedge clk);
        clr_warn = w; clr_crit = c; clr_uv = u; clr_ov = o;
        @(negedge clk);
        clr_warn = '0; clr_crit = '0; clr_uv = '0; clr_ov = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_state("R1 reset", 3'b000, 3'b000, 3'b000, 3'b000, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            sample(TABLE[v].is_rail, TABLE[v].chan, TABLE[v].code);
            check_state($sformatf("table %0d (R2 R3 R5 R8 R9 R10 R11)", v),
                        TABLE[v].ew, TABLE[v].ec, TABLE[v].eu, TABLE[v].eo, TABLE[v].esd);
        end

        // R7: clear site 0 warning only
        clear(3'b001, 3'b000, 3'b000, 3'b000);
        check_state("R7 selective clear", 3'b110, 3'b010, 3'b001, 3'b100, 1'b1);

        // R6: site 0 still fired, over samples do not re-set it
        sample(1'b0, 2'd0, 10'd401);
        sample(1'b0, 2'd0, 10'd401);
        check_state("R6 no refire while fired", 3'b110, 3'b010, 3'b001, 3'b100, 1'b1);
        sample(1'b0, 2'd0, 10'd385);
        sample(1'b0, 2'd0, 10'd400);
        sample(1'b0, 2'd0, 10'd400);
        check_state("R6 inside band no rearm", 3'b110, 3'b010, 3'b001, 3'b100, 1'b1);
        sample(1'b0, 2'd0, 10'd379);
        sample(1'b0, 2'd0, 10'd400);
        sample(1'b0, 2'd0, 10'd400);
        check_state("R6 rearm past band", 3'b111, 3'b010, 3'b001, 3'b100, 1'b1);

        // R4: clearing critical status and cool readings keep shutdown
        clear(3'b000, 3'b111, 3'b000, 3'b000);
        check_state("R4 crit cleared", 3'b111, 3'b000, 3'b001, 3'b100, 1'b1);
        sample(1'b0, 2'd1, 10'd0);
        check_state("R4 shutdown held", 3'b111, 3'b000, 3'b001, 3'b100, 1'b1);

        // R5: persist 0 behaves as 1
        persist = 4'd0;
        sample(1'b0, 2'd0, 10'd600);
        check_state("R5 persist zero", 3'b111, 3'b001, 3'b001, 3'b100, 1'b1);

        // R7 / R10: clear all rail status drops rail_irq
        clear(3'b000, 3'b000, 3'b111, 3'b111);
        check_state("R10 rail clear", 3'b111, 3'b001, 3'b000, 3'b000, 1'b1);

        // R1: reset mid-run clears everything including shutdown
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_state("R1 reset after alarms", 3'b000, 3'b000, 3'b000, 3'b000, 1'b0);
        rst_n = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule